// File: doc/BRIEF.md
# Branch Prediction History Queue

This block keeps, for each hardware thread, an age-ordered list of the branch predictions still in flight. The fetch side offers a new record on the predict port. The record carries the sequence number, the branch PC, the predicted direction and target, the call, return and indirect flags, two flags that say whether the prediction read the return-address stack or pushed onto it, and the stack checkpoint (index and target) taken at prediction time. Accepted records join the young end of that thread's list.

Retirement and recovery run as multi-cycle operations that handle one record per clock. A commit request names a thread and a sequence number. Records leave from the old end and appear on the retire outputs, so the direction predictors can be trained. A squash request names a thread and a sequence number. Records leave from the young end, youngest first, and for each one the block emits the return-address-stack repair it needs. When the squash is flagged as a mispredict, the surviving youngest record is then rewritten in place with the resolved outcome, and any stack repair that the outcome implies is also emitted.

Top module: `bhq_history_queue`

## Requirements
- R1: While `busy` is low, the thread's queue holds fewer than DEPTH records, and neither `commit_valid` nor `squash_valid` is high, `pred_ready` is high. A record offered with `pred_valid` in such a cycle joins the young end of the queue selected by `pred_tid`.
- R2: When the selected thread's queue holds DEPTH records, `pred_ready` is low and the offered record is dropped. Each thread's queue fills independently of the others.
- R3: A commit for sequence number N retires records oldest first, one per clock, while the oldest record's sequence number is at most N. Sequence numbers compare as unsigned values. Each retired record is shown for one cycle with `retire_valid` high.
- R4: A squash for sequence number S removes records youngest first, one per clock, while the youngest record's sequence number is greater than S.
- R5: For each record that a squash removes: if its stack-use flag is set, `repair_restore` pulses and carries the record's saved index and target. Otherwise, if it is a call with its pushed flag set, `repair_undo_pop` pulses. Otherwise nothing is emitted. The two repair outputs are never high together.
- R6: `busy` is high from the cycle after an accepted commit or squash until that operation ends. While `busy` is high, `pred_ready` is low, and commit and squash requests are ignored.
- R7: On a mispredict for S, once the younger records are gone, a youngest record whose sequence number equals S takes the resolved direction and target. The new values are seen when that record retires.
- R8: When a mispredicted record is resolved not taken: if its stack-use flag is set, a restore is emitted and the flag is cleared. Otherwise, if it is a call with its pushed flag set, an undo-pop is emitted and the pushed flag is cleared.
- R9: When a mispredicted return whose stack-use flag is clear is resolved taken, that flag is set and no repair is emitted.
- R10: A mispredict that leaves the queue empty updates nothing and raises no error.
- R11: A mispredict whose youngest surviving record does not carry S sets `seq_error`. The flag stays set until reset, and the record is left unchanged.
- R12: After reset every queue is empty, `busy`, `seq_error`, `retire_valid` and both repair outputs are low, and `pred_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | New prediction record offered |
| pred_ready | output | 1 | Record accepted this cycle |
| pred_tid | input | TID_W | Thread of the offered record |
| pred_seq | input | SEQ_W | Sequence number |
| pred_pc | input | PC_W | Branch PC |
| pred_taken | input | 1 | Predicted direction |
| pred_target | input | PC_W | Predicted target |
| pred_is_call | input | 1 | Record is a call |
| pred_is_ret | input | 1 | Record is a return |
| pred_is_ind | input | 1 | Record is an indirect branch |
| pred_used_ras | input | 1 | Prediction read the return stack |
| pred_pushed_ras | input | 1 | Prediction pushed the return stack |
| pred_ras_idx | input | RIDX_W | Saved stack index |
| pred_ras_tgt | input | PC_W | Saved stack top target |
| commit_valid | input | 1 | Commit request |
| commit_tid | input | TID_W | Commit thread |
| commit_seq | input | SEQ_W | Retire up to this sequence number |
| squash_valid | input | 1 | Squash request |
| squash_tid | input | TID_W | Squash thread |
| squash_seq | input | SEQ_W | Keep records up to this sequence number |
| squash_mispredict | input | 1 | Correct the record at squash_seq afterwards |
| squash_taken | input | 1 | Resolved direction |
| squash_target | input | PC_W | Resolved target |
| busy | output | 1 | Commit or squash in progress |
| retire_valid | output | 1 | Retired record shown |
| retire_tid | output | TID_W | Thread of retired record |
| retire_seq | output | SEQ_W | Retired sequence number |
| retire_pc | output | PC_W | Retired PC |
| retire_taken | output | 1 | Retired direction |
| retire_target | output | PC_W | Retired target |
| retire_indirect | output | 1 | Retired record was indirect |
| retire_used_ras | output | 1 | Retired stack-use flag |
| retire_pushed_ras | output | 1 | Retired pushed flag |
| repair_restore | output | 1 | Restore stack to saved index and target |
| repair_undo_pop | output | 1 | Pop the entry a squashed call pushed |
| repair_tid | output | TID_W | Thread to repair |
| repair_ras_idx | output | RIDX_W | Saved stack index |
| repair_ras_tgt | output | PC_W | Saved stack target |
| seq_error | output | 1 | Sticky mispredict sequence mismatch |

## Verification
A corrupted queue pointer or slot shows in two ways: a wrong sequence number or field on the retire outputs at the next commit, or a wrong count or order of repair pulses during the next squash. The delay is one clock per record the operation passes over. A wrong in-place correction stays hidden until that record retires, so each mispredict case is followed by a commit, and the retired direction, target and stack flags are compared. A bad full count shows at once, because `pred_ready` is wrong on the very next offer.

// File: rtl/bhq_pkg.sv
`timescale 1ns/1ps
package bhq_pkg;
   typedef enum logic [1:0] {
      ENG_IDLE   = 2'd0,
      ENG_COMMIT = 2'd1,
      ENG_SQUASH = 2'd2
   } eng_state_e;
endpackage

// File: rtl/bhq_ring.sv
`timescale 1ns/1ps
// One thread's age-ordered record list: append young, drop old or young,
// rewrite the youngest slot.
module bhq_ring #(
   parameter int DEPTH = 8,
   parameter int REC_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [REC_W-1:0] push_rec,
   input  logic             pop_old,
   input  logic             pop_young,
   input  logic             fix_we,
   input  logic [REC_W-1:0] fix_rec,
   output logic [REC_W-1:0] old_rec,
   output logic [REC_W-1:0] yng_rec,
   output logic             full,
   output logic             empty
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [REC_W-1:0] slots [DEPTH];
   logic [PTR_W-1:0] head;
   logic [CNT_W-1:0] cnt;
   logic [PTR_W-1:0] tail_idx, yng_idx;

   function automatic logic [PTR_W-1:0] wrap_add(input logic [PTR_W-1:0] base,
                                                 input logic [CNT_W-1:0] off);
      int s;
      s = int'(base) + int'(off);
      if (s >= DEPTH) s = s - DEPTH;
      return s[PTR_W-1:0];
   endfunction

   assign tail_idx = wrap_add(head, cnt);
   assign yng_idx  = (cnt == '0) ? head : wrap_add(head, cnt - CNT_W'(1));
   assign full     = (cnt == CNT_W'(DEPTH));
   assign empty    = (cnt == '0);
   assign old_rec  = slots[head];
   assign yng_rec  = slots[yng_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head <= '0;
         cnt  <= '0;
      end else if (push) begin
         cnt <= cnt + CNT_W'(1);
      end else if (pop_old) begin
         head <= wrap_add(head, CNT_W'(1));
         cnt  <= cnt - CNT_W'(1);
      end else if (pop_young) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push)        slots[tail_idx] <= push_rec;
      else if (fix_we) slots[yng_idx]  <= fix_rec;
   end

   a_r2_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r3_no_remove_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_old || pop_young || fix_we) |-> !empty);
   a_r6_one_action: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({push, pop_old, pop_young, fix_we}));
   a_r1_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> !empty);
endmodule

// File: rtl/bhq_engine.sv
`timescale 1ns/1ps
// Sequencer for commit and squash: one record per clock, then idle.
module bhq_engine
   import bhq_pkg::*;
#(
   parameter int SEQ_W = 16,
   parameter int TID_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit_valid,
   input  logic [TID_W-1:0] commit_tid,
   input  logic [SEQ_W-1:0] commit_seq,
   input  logic             squash_valid,
   input  logic [TID_W-1:0] squash_tid,
   input  logic [SEQ_W-1:0] squash_seq,
   input  logic             squash_misp,
   input  logic             sel_empty,
   input  logic [SEQ_W-1:0] sel_old_seq,
   input  logic [SEQ_W-1:0] sel_yng_seq,
   output logic             busy,
   output logic             accept_squash,
   output logic [TID_W-1:0] op_tid,
   output logic [SEQ_W-1:0] op_seq,
   output logic             commit_pop,
   output logic             squash_pop,
   output logic             fix_hit,
   output logic             fix_miss
);
   eng_state_e state, state_nx;
   logic       op_misp;
   logic       accept_commit, squash_end;

   assign busy          = (state != ENG_IDLE);
   assign accept_squash = !busy && squash_valid;
   assign accept_commit = !busy && commit_valid && !squash_valid;

   assign commit_pop = (state == ENG_COMMIT) && !sel_empty && (sel_old_seq <= op_seq);
   assign squash_pop = (state == ENG_SQUASH) && !sel_empty && (sel_yng_seq > op_seq);
   assign squash_end = (state == ENG_SQUASH) && !squash_pop;
   assign fix_hit    = squash_end && op_misp && !sel_empty && (sel_yng_seq == op_seq);
   assign fix_miss   = squash_end && op_misp && !sel_empty && (sel_yng_seq != op_seq);

   always_comb begin
      state_nx = state;
      case (state)
         ENG_IDLE: begin
            if (accept_squash)      state_nx = ENG_SQUASH;
            else if (accept_commit) state_nx = ENG_COMMIT;
         end
         ENG_COMMIT: if (!commit_pop) state_nx = ENG_IDLE;
         ENG_SQUASH: if (!squash_pop) state_nx = ENG_IDLE;
         default:    state_nx = ENG_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ENG_IDLE;
         op_tid  <= '0;
         op_seq  <= '0;
         op_misp <= 1'b0;
      end else begin
         state <= state_nx;
         if (accept_squash) begin
            op_tid  <= squash_tid;
            op_seq  <= squash_seq;
            op_misp <= squash_misp;
         end else if (accept_commit) begin
            op_tid  <= commit_tid;
            op_seq  <= commit_seq;
            op_misp <= 1'b0;
         end
      end
   end

   a_r6_busy_after_request: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && (commit_valid || squash_valid)) |=> busy);
   a_r6_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(op_seq) && $stable(op_tid)));
   a_r7_fix_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
      (fix_hit || fix_miss) |=> !busy);
   a_r4_no_pop_while_committing: assert property (@(posedge clk) disable iff (!rst_n)
      !(commit_pop && (squash_pop || fix_hit)));
endmodule

// File: rtl/bhq_history_queue.sv
`timescale 1ns/1ps
module bhq_history_queue #(
   parameter int NT     = 2,
   parameter int DEPTH  = 8,
   parameter int SEQ_W  = 16,
   parameter int PC_W   = 32,
   parameter int RIDX_W = 4,
   localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_valid,
   output logic              pred_ready,
   input  logic [TID_W-1:0]  pred_tid,
   input  logic [SEQ_W-1:0]  pred_seq,
   input  logic [PC_W-1:0]   pred_pc,
   input  logic              pred_taken,
   input  logic [PC_W-1:0]   pred_target,
   input  logic              pred_is_call,
   input  logic              pred_is_ret,
   input  logic              pred_is_ind,
   input  logic              pred_used_ras,
   input  logic              pred_pushed_ras,
   input  logic [RIDX_W-1:0] pred_ras_idx,
   input  logic [PC_W-1:0]   pred_ras_tgt,
   input  logic              commit_valid,
   input  logic [TID_W-1:0]  commit_tid,
   input  logic [SEQ_W-1:0]  commit_seq,
   input  logic              squash_valid,
   input  logic [TID_W-1:0]  squash_tid,
   input  logic [SEQ_W-1:0]  squash_seq,
   input  logic              squash_mispredict,
   input  logic              squash_taken,
   input  logic [PC_W-1:0]   squash_target,
   output logic              busy,
   output logic              retire_valid,
   output logic [TID_W-1:0]  retire_tid,
   output logic [SEQ_W-1:0]  retire_seq,
   output logic [PC_W-1:0]   retire_pc,
   output logic              retire_taken,
   output logic [PC_W-1:0]   retire_target,
   output logic              retire_indirect,
   output logic              retire_used_ras,
   output logic              retire_pushed_ras,
   output logic              repair_restore,
   output logic              repair_undo_pop,
   output logic [TID_W-1:0]  repair_tid,
   output logic [RIDX_W-1:0] repair_ras_idx,
   output logic [PC_W-1:0]   repair_ras_tgt,
   output logic              seq_error
);
   typedef struct packed {
      logic [SEQ_W-1:0]  seq;
      logic [PC_W-1:0]   pc;
      logic              taken;
      logic [PC_W-1:0]   target;
      logic              is_call;
      logic              is_ret;
      logic              is_ind;
      logic              used_ras;
      logic              pushed_ras;
      logic [RIDX_W-1:0] ras_idx;
      logic [PC_W-1:0]   ras_tgt;
   } rec_t;
   localparam int REC_W = $bits(rec_t);

   if (NT < 1)     begin : g_bad_nt    $error("NT must be at least 1");    end
   if (DEPTH < 2)  begin : g_bad_depth $error("DEPTH must be at least 2"); end
   if (SEQ_W < 2)  begin : g_bad_seq   $error("SEQ_W must be at least 2"); end
   if (RIDX_W < 1) begin : g_bad_ridx  $error("RIDX_W must be positive");  end

   logic [REC_W-1:0] old_flat [NT];
   logic [REC_W-1:0] yng_flat [NT];
   logic [NT-1:0]    full_v, empty_v;
   rec_t             in_rec, sel_old, sel_yng, fix_rec;
   logic             fx_taken;
   logic [PC_W-1:0]  fx_target;
   logic [TID_W-1:0] eng_tid;
   logic [SEQ_W-1:0] eng_seq;
   logic             accept_squash, commit_pop, squash_pop, fix_hit, fix_miss;
   logic             take_pred, rst_now, pop_now;

   assign pred_ready = !busy && !commit_valid && !squash_valid && !full_v[pred_tid];
   assign take_pred  = pred_valid && pred_ready;

   always_comb begin
      in_rec            = '0;
      in_rec.seq        = pred_seq;
      in_rec.pc         = pred_pc;
      in_rec.taken      = pred_taken;
      in_rec.target     = pred_target;
      in_rec.is_call    = pred_is_call;
      in_rec.is_ret     = pred_is_ret;
      in_rec.is_ind     = pred_is_ind;
      in_rec.used_ras   = pred_used_ras;
      in_rec.pushed_ras = pred_pushed_ras;
      in_rec.ras_idx    = pred_ras_idx;
      in_rec.ras_tgt    = pred_ras_tgt;
   end

   for (genvar t = 0; t < NT; t++) begin : g_thread
      logic mine;
      assign mine = (eng_tid == TID_W'(t));
      bhq_ring #(.DEPTH(DEPTH), .REC_W(REC_W)) u_ring (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (take_pred && (pred_tid == TID_W'(t))),
         .push_rec  (in_rec),
         .pop_old   (commit_pop && mine),
         .pop_young (squash_pop && mine),
         .fix_we    (fix_hit && mine),
         .fix_rec   (fix_rec),
         .old_rec   (old_flat[t]),
         .yng_rec   (yng_flat[t]),
         .full      (full_v[t]),
         .empty     (empty_v[t])
      );
   end

   assign sel_old = old_flat[eng_tid];
   assign sel_yng = yng_flat[eng_tid];

   bhq_engine #(.SEQ_W(SEQ_W), .TID_W(TID_W)) u_engine (
      .clk           (clk),
      .rst_n         (rst_n),
      .commit_valid  (commit_valid),
      .commit_tid    (commit_tid),
      .commit_seq    (commit_seq),
      .squash_valid  (squash_valid),
      .squash_tid    (squash_tid),
      .squash_seq    (squash_seq),
      .squash_misp   (squash_mispredict),
      .sel_empty     (empty_v[eng_tid]),
      .sel_old_seq   (sel_old.seq),
      .sel_yng_seq   (sel_yng.seq),
      .busy          (busy),
      .accept_squash (accept_squash),
      .op_tid        (eng_tid),
      .op_seq        (eng_seq),
      .commit_pop    (commit_pop),
      .squash_pop    (squash_pop),
      .fix_hit       (fix_hit),
      .fix_miss      (fix_miss)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fx_taken  <= 1'b0;
         fx_target <= '0;
      end else if (accept_squash) begin
         fx_taken  <= squash_taken;
         fx_target <= squash_target;
      end
   end

   // In-place correction of the record at the squash point.
   always_comb begin
      fix_rec        = sel_yng;
      fix_rec.taken  = fx_taken;
      fix_rec.target = fx_target;
      if (fx_taken) begin
         fix_rec.used_ras = sel_yng.used_ras | sel_yng.is_ret;
      end else if (sel_yng.used_ras) begin
         fix_rec.used_ras = 1'b0;
      end else if (sel_yng.is_call && sel_yng.pushed_ras) begin
         fix_rec.pushed_ras = 1'b0;
      end
   end

   assign rst_now = (squash_pop || (fix_hit && !fx_taken)) && sel_yng.used_ras;
   assign pop_now = (squash_pop || (fix_hit && !fx_taken)) && !sel_yng.used_ras
                    && sel_yng.is_call && sel_yng.pushed_ras;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         retire_valid      <= 1'b0;
         retire_tid        <= '0;
         retire_seq        <= '0;
         retire_pc         <= '0;
         retire_taken      <= 1'b0;
         retire_target     <= '0;
         retire_indirect   <= 1'b0;
         retire_used_ras   <= 1'b0;
         retire_pushed_ras <= 1'b0;
         repair_restore    <= 1'b0;
         repair_undo_pop   <= 1'b0;
         repair_tid        <= '0;
         repair_ras_idx    <= '0;
         repair_ras_tgt    <= '0;
         seq_error         <= 1'b0;
      end else begin
         retire_valid <= commit_pop;
         if (commit_pop) begin
            retire_tid        <= eng_tid;
            retire_seq        <= sel_old.seq;
            retire_pc         <= sel_old.pc;
            retire_taken      <= sel_old.taken;
            retire_target     <= sel_old.target;
            retire_indirect   <= sel_old.is_ind;
            retire_used_ras   <= sel_old.used_ras;
            retire_pushed_ras <= sel_old.pushed_ras;
         end
         repair_restore  <= rst_now;
         repair_undo_pop <= pop_now;
         if (rst_now || pop_now) begin
            repair_tid     <= eng_tid;
            repair_ras_idx <= sel_yng.ras_idx;
            repair_ras_tgt <= sel_yng.ras_tgt;
         end
         seq_error <= seq_error | fix_miss;
      end
   end

   a_r5_repair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(repair_restore && repair_undo_pop));
   a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      seq_error |=> seq_error);
   a_r6_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !pred_ready);
   a_r3_retire_bound: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |-> (retire_seq <= eng_seq));
endmodule

// File: tb/bhq_history_queue_test.sv
`timescale 1ns/1ps
module bhq_history_queue_test;
   localparam int NT = 2, DEPTH = 4, SEQ_W = 8, PC_W = 16, RIDX_W = 4;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n;
   logic pred_valid, pred_ready, pred_tid;
   logic [7:0] pred_seq;
   logic [15:0] pred_pc, pred_target, pred_ras_tgt;
   logic pred_taken, pred_is_call, pred_is_ret, pred_is_ind, pred_used_ras, pred_pushed_ras;
   logic [3:0] pred_ras_idx;
   logic commit_valid, commit_tid;
   logic [7:0] commit_seq;
   logic squash_valid, squash_tid, squash_mispredict, squash_taken;
   logic [7:0] squash_seq;
   logic [15:0] squash_target;
   logic busy, retire_valid, retire_tid, retire_taken, retire_indirect;
   logic retire_used_ras, retire_pushed_ras;
   logic [7:0] retire_seq;
   logic [15:0] retire_pc, retire_target, repair_ras_tgt;
   logic repair_restore, repair_undo_pop, repair_tid, seq_error;
   logic [3:0] repair_ras_idx;

   bhq_history_queue #(.NT(NT), .DEPTH(DEPTH), .SEQ_W(SEQ_W), .PC_W(PC_W), .RIDX_W(RIDX_W)) uut (
      .clk(clk), .rst_n(rst_n),
      .pred_valid(pred_valid), .pred_ready(pred_ready), .pred_tid(pred_tid),
      .pred_seq(pred_seq), .pred_pc(pred_pc), .pred_taken(pred_taken),
      .pred_target(pred_target), .pred_is_call(pred_is_call), .pred_is_ret(pred_is_ret),
      .pred_is_ind(pred_is_ind), .pred_used_ras(pred_used_ras),
      .pred_pushed_ras(pred_pushed_ras), .pred_ras_idx(pred_ras_idx),
      .pred_ras_tgt(pred_ras_tgt),
      .commit_valid(commit_valid), .commit_tid(commit_tid), .commit_seq(commit_seq),
      .squash_valid(squash_valid), .squash_tid(squash_tid), .squash_seq(squash_seq),
      .squash_mispredict(squash_mispredict), .squash_taken(squash_taken),
      .squash_target(squash_target),
      .busy(busy),
      .retire_valid(retire_valid), .retire_tid(retire_tid), .retire_seq(retire_seq),
      .retire_pc(retire_pc), .retire_taken(retire_taken), .retire_target(retire_target),
      .retire_indirect(retire_indirect), .retire_used_ras(retire_used_ras),
      .retire_pushed_ras(retire_pushed_ras),
      .repair_restore(repair_restore), .repair_undo_pop(repair_undo_pop),
      .repair_tid(repair_tid), .repair_ras_idx(repair_ras_idx),
      .repair_ras_tgt(repair_ras_tgt), .seq_error(seq_error)
   );

   int checks = 0, fails = 0;
   bit finished = 0;

   // Events seen on the retire and repair outputs.
   int ret_n = 0, rep_n = 0, rep_rst_n = 0;
   logic [7:0]  ret_seq [32];
   logic        ret_tk [32];
   logic [15:0] ret_tg [32];
   logic        ret_used [32];
   logic        ret_push [32];
   logic [3:0]  rep_idx [32];

   always @(negedge clk) begin
      if (rst_n) begin
         if (retire_valid && ret_n < 32) begin
            ret_seq[ret_n]  = retire_seq;
            ret_tk[ret_n]   = retire_taken;
            ret_tg[ret_n]   = retire_target;
            ret_used[ret_n] = retire_used_ras;
            ret_push[ret_n] = retire_pushed_ras;
            ret_n++;
         end
         if ((repair_restore || repair_undo_pop) && rep_n < 32) begin
            rep_idx[rep_n] = repair_ras_idx;
            if (repair_restore) rep_rst_n++;
            rep_n++;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_predict(input logic tid, input logic [7:0] seq, input logic [3:0] fl,
                             input logic tk, input logic [15:0] tgt, output logic rdy);
      @(negedge clk);
      pred_valid = 1'b1; pred_tid = tid; pred_seq = seq; pred_pc = 16'(seq) * 16'd4;
      pred_taken = tk; pred_target = tgt;
      pred_is_call = fl[3]; pred_is_ret = fl[2]; pred_used_ras = fl[1]; pred_pushed_ras = fl[0];
      pred_is_ind = 1'b0; pred_ras_idx = seq[3:0]; pred_ras_tgt = 16'(seq) + 16'd200;
      #1 rdy = pred_ready;
      @(negedge clk);
      pred_valid = 1'b0;
   endtask

   task automatic wait_idle();
      int guard = 0;
      @(negedge clk);
      while (busy && guard < 1000) begin
         @(negedge clk);
         guard++;
      end
      @(negedge clk);
   endtask

   task automatic clear_events();
      ret_n = 0; rep_n = 0; rep_rst_n = 0;
   endtask

   task automatic do_commit(input logic tid, input logic [7:0] n);
      @(negedge clk);
      clear_events();
      commit_valid = 1'b1; commit_tid = tid; commit_seq = n;
      @(negedge clk);
      commit_valid = 1'b0;
      wait_idle();
   endtask

   task automatic do_squash(input logic tid, input logic [7:0] s, input logic misp,
                            input logic tk, input logic [15:0] tgt);
      @(negedge clk);
      clear_events();
      squash_valid = 1'b1; squash_tid = tid; squash_seq = s;
      squash_mispredict = misp; squash_taken = tk; squash_target = tgt;
      @(negedge clk);
      squash_valid = 1'b0;
      pred_tid = tid;
      #1;
      chk("R6", "busy during squash", int'(busy), 1);
      chk("R6", "ready during squash", int'(pred_ready), 0);
      wait_idle();
   endtask

   // Vector: op[39:38] tid[37] seq[36:29] flags{call,ret,used,pushed}[28:25]
   //         n[24:21] restores[20:17] first[16:9] last[8:1]
   localparam int NV = 11;
   localparam logic [39:0] VEC [NV] = '{
      {2'd0, 1'b0, 8'd1, 4'b1001, 4'd1, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd0, 1'b0, 8'd2, 4'b0000, 4'd1, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd0, 1'b0, 8'd3, 4'b0110, 4'd1, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd0, 1'b0, 8'd4, 4'b1001, 4'd1, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd0, 1'b0, 8'd5, 4'b0000, 4'd0, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd0, 1'b1, 8'd6, 4'b0000, 4'd1, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd1, 1'b0, 8'd2, 4'b0000, 4'd2, 4'd0, 8'd1, 8'd2, 1'b0},
      {2'd2, 1'b0, 8'd2, 4'b0000, 4'd2, 4'd1, 8'd4, 8'd3, 1'b0},
      {2'd1, 1'b1, 8'd5, 4'b0000, 4'd0, 4'd0, 8'd0, 8'd0, 1'b0},
      {2'd1, 1'b1, 8'd6, 4'b0000, 4'd1, 4'd0, 8'd6, 8'd6, 1'b0},
      {2'd2, 1'b0, 8'd9, 4'b0000, 4'd0, 4'd0, 8'd0, 8'd0, 1'b0}
   };

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         summary();
         $finish;
      end
   end

   initial begin
      logic rdy;
      rst_n = 1'b0;
      pred_valid = 0; pred_tid = 0; pred_seq = 0; pred_pc = 0; pred_taken = 0;
      pred_target = 0; pred_is_call = 0; pred_is_ret = 0; pred_is_ind = 0;
      pred_used_ras = 0; pred_pushed_ras = 0; pred_ras_idx = 0; pred_ras_tgt = 0;
      commit_valid = 0; commit_tid = 0; commit_seq = 0;
      squash_valid = 0; squash_tid = 0; squash_seq = 0; squash_mispredict = 0;
      squash_taken = 0; squash_target = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R12: reset state
      chk("R12", "busy", int'(busy), 0);
      chk("R12", "seq_error", int'(seq_error), 0);
      chk("R12", "retire_valid", int'(retire_valid), 0);
      chk("R12", "repair", int'(repair_restore | repair_undo_pop), 0);
      chk("R12", "pred_ready", int'(pred_ready), 1);

      // Vector table
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         v = VEC[i];
         case (v[39:38])
            2'd0: begin
               do_predict(v[37], v[36:29], v[28:25], 1'b1, 16'(v[36:29]) + 16'd100, rdy);
               chk(v[24:21] != 0 ? "R1" : "R2", "pred_ready", int'(rdy), int'(v[24:21]));
            end
            2'd1: begin
               do_commit(v[37], v[36:29]);
               chk("R3", "retired count", ret_n, int'(v[24:21]));
               if (v[24:21] != 0 && ret_n > 0) begin
                  chk("R3", "first retired seq", int'(ret_seq[0]), int'(v[16:9]));
                  chk("R3", "last retired seq", int'(ret_seq[ret_n-1]), int'(v[8:1]));
               end
            end
            default: begin
               do_squash(v[37], v[36:29], 1'b0, 1'b0, 16'd0);
               chk("R4", "repair count", rep_n, int'(v[24:21]));
               chk("R5", "restore count", rep_rst_n, int'(v[20:17]));
               if (v[24:21] != 0 && rep_n > 0) begin
                  chk("R5", "first repair idx", int'(rep_idx[0]), int'(v[16:9]));
                  chk("R5", "last repair idx", int'(rep_idx[rep_n-1]), int'(v[8:1]));
               end
            end
         endcase
      end

      // R7 / R9: taken return without stack use gets its flag set
      do_predict(1'b0, 8'd10, 4'b0100, 1'b0, 16'd110, rdy);
      do_predict(1'b0, 8'd11, 4'b0000, 1'b1, 16'd111, rdy);
      do_predict(1'b0, 8'd12, 4'b1001, 1'b1, 16'd112, rdy);
      do_squash(1'b0, 8'd10, 1'b1, 1'b1, 16'h0055);
      chk("R5", "repairs on mispredict squash", rep_n, 1);
      chk("R5", "undo-pop idx", int'(rep_idx[0]), 12);
      chk("R9", "restores", rep_rst_n, 0);
      do_commit(1'b0, 8'd10);
      chk("R7", "retired count", ret_n, 1);
      chk("R7", "corrected taken", int'(ret_tk[0]), 1);
      chk("R7", "corrected target", int'(ret_tg[0]), 16'h55);
      chk("R9", "used flag set", int'(ret_used[0]), 1);

      // R8: not-taken resolution of a record that used the stack
      do_predict(1'b0, 8'd20, 4'b0110, 1'b1, 16'd120, rdy);
      do_squash(1'b0, 8'd20, 1'b1, 1'b0, 16'h0021);
      chk("R8", "restore count", rep_rst_n, 1);
      chk("R8", "restore idx", int'(rep_idx[0]), 4);
      do_commit(1'b0, 8'd20);
      chk("R8", "used flag cleared", int'(ret_used[0]), 0);
      chk("R7", "target rewritten", int'(ret_tg[0]), 16'h21);

      // R8: not-taken resolution of a call that pushed
      do_predict(1'b0, 8'd50, 4'b1001, 1'b1, 16'd150, rdy);
      do_squash(1'b0, 8'd50, 1'b1, 1'b0, 16'h0033);
      chk("R8", "undo-pop count", rep_n - rep_rst_n, 1);
      chk("R8", "undo-pop idx", int'(rep_idx[0]), 2);
      do_commit(1'b0, 8'd50);
      chk("R8", "pushed flag cleared", int'(ret_push[0]), 0);
      chk("R7", "direction rewritten", int'(ret_tk[0]), 0);

      // R10: mispredict that empties the queue
      do_predict(1'b0, 8'd30, 4'b0000, 1'b1, 16'd130, rdy);
      do_squash(1'b0, 8'd25, 1'b1, 1'b0, 16'h0044);
      chk("R10", "repairs", rep_n, 0);
      chk("R10", "seq_error", int'(seq_error), 0);
      do_commit(1'b0, 8'd255);
      chk("R10", "queue empty", ret_n, 0);

      // R11: sequence mismatch
      do_predict(1'b0, 8'd40, 4'b0000, 1'b1, 16'd140, rdy);
      do_squash(1'b0, 8'd45, 1'b1, 1'b0, 16'h0099);
      chk("R11", "seq_error set", int'(seq_error), 1);
      chk("R11", "repairs", rep_n, 0);
      do_commit(1'b0, 8'd255);
      chk("R11", "record untouched taken", int'(ret_tk[0]), 1);
      chk("R11", "record untouched target", int'(ret_tg[0]), 140);
      chk("R11", "seq_error sticky", int'(seq_error), 1);

      // R6: commit request during a squash is ignored
      do_predict(1'b1, 8'd60, 4'b0000, 1'b1, 16'd160, rdy);
      do_predict(1'b0, 8'd70, 4'b0000, 1'b1, 16'd170, rdy);
      do_predict(1'b0, 8'd71, 4'b0000, 1'b1, 16'd171, rdy);
      do_predict(1'b0, 8'd72, 4'b0000, 1'b1, 16'd172, rdy);
      @(negedge clk);
      clear_events();
      squash_valid = 1'b1; squash_tid = 1'b0; squash_seq = 8'd69; squash_mispredict = 1'b0;
      @(negedge clk);
      squash_valid = 1'b0;
      commit_valid = 1'b1; commit_tid = 1'b1; commit_seq = 8'd255;
      @(negedge clk);
      commit_valid = 1'b0;
      wait_idle();
      chk("R6", "retires from ignored commit", ret_n, 0);
      do_commit(1'b1, 8'd255);
      chk("R6", "thread 1 record kept", ret_n, 1);
      chk("R6", "thread 1 seq", int'(ret_seq[0]), 60);

      finished = 1;
      summary();
      $finish;
   end
endmodule